// File: doc/BRIEF.md
# Signaling NaN Quieting Unit

This is a purely combinational unit that examines one 32-bit single-precision floating-point value and decides whether it is a signaling NaN. When it is, the unit rewrites it as a quiet NaN and raises the invalid-operation flag. Any other value leaves the unit bit for bit as it arrived, and no flag is raised.

A mode input selects how the top fraction bit is read. In the 2008 encoding a set top fraction bit marks a quiet NaN. In the legacy encoding a set top fraction bit marks a signaling NaN. The unit sits in an operand path ahead of an arithmetic datapath, or on a result path that must never hand a signaling NaN onward. Its exception flag is meant to be merged into a wider flag set.

Top module: `snq_unit`

## Requirements
- R1: A value counts as a NaN only when its exponent field (bits 30:23) is all ones and its fraction field (bits 22:0) is not zero. Zeros, normals, subnormals and infinities are never reported as signaling.
- R2: A NaN is signaling when the mode bit XOR fraction bit 22 equals 1. Mode 1 selects the 2008 encoding, where a clear bit 22 means signaling. Mode 0 selects the legacy encoding, where a set bit 22 means signaling. The `is_snan` output reports this decision.
- R3: The `invalid` output is 1 exactly when the input is a signaling NaN under the current mode.
- R4: In mode 1, quieting sets fraction bit 22 and leaves fraction bits 21:0 unchanged.
- R5: In mode 0, quieting clears fraction bit 22. When bits 21:0 are not all zero, they are left unchanged.
- R6: In mode 0, when clearing bit 22 would leave a zero fraction (the input fraction is 0x400000), the output fraction is 0x200000, so the result does not read as infinity.
- R7: During quieting, the sign bit (bit 31) and the exponent field pass through unchanged.
- R8: An input that is not a signaling NaN under the current mode (including a quiet NaN) appears unmodified on `op_out`, with `is_snan` and `invalid` both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_in | input | 32 | Single-precision operand: sign in bit 31, exponent in bits 30:23, fraction in bits 22:0 |
| nan2008_mode | input | 1 | NaN encoding select: 1 selects the 2008 encoding, 0 selects the legacy encoding |
| op_out | output | 32 | The operand, quieted when it was a signaling NaN, otherwise unchanged |
| is_snan | output | 1 | The operand is a signaling NaN under the selected encoding |
| invalid | output | 1 | Invalid-operation flag raised by quieting |

## Verification
The assertions check, on every evaluation, the following relations:
- the flag agrees with the signaling indication;
- a signaling indication only ever comes with an all-ones exponent and a nonzero fraction;
- sign and exponent survive quieting;
- a quieted result is itself a NaN whose bit 22 now reads as quiet in the current mode;
- non-signaling inputs pass through intact.

Only the bench's scenarios can show the exact output fraction. This covers bits 21:0 being kept, and the legacy-mode substitution of bit 21 when the payload holds only bit 22. The scenarios also show that each payload corner is classified correctly in both modes.

// File: rtl/snq_pkg.sv
// Package: shared field widths and the operand layout for the NaN
// quieting unit. Assumes an IEEE-style layout of sign, biased exponent
// and fraction, packed from the most significant bit downward.
package snq_pkg;
    parameter int EXP_W  = 8;
    parameter int FRAC_W = 23;
    localparam int DATA_W = 1 + EXP_W + FRAC_W;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;
endpackage

// File: rtl/snq_classify.sv
// Module: decides whether an operand is a NaN and, if so, whether it is
// signaling under the selected encoding. Purely combinational.
// Assumes: the fraction is at least two bits wide; the top fraction bit
// is the quiet/signal discriminator.
module snq_classify
    import snq_pkg::*;
(
    input  logic [EXP_W-1:0]  expo,
    input  logic [FRAC_W-1:0] frac,
    input  logic              enc2008,
    output logic              sig_nan
);
    localparam int QPOS = FRAC_W - 1;

    logic exp_full;
    logic frac_any;
    logic any_nan;

    // Detect the all-ones exponent and nonzero fraction of a NaN.
    always_comb begin
        exp_full = &expo;
        frac_any = |frac;
        any_nan  = exp_full && frac_any;
    end

    // A NaN signals when the encoding bit and the discriminator differ.
    always_comb begin
        sig_nan = any_nan && (enc2008 ^ frac[QPOS]);
    end
endmodule

// File: rtl/snq_quiet.sv
// Module: produces the quieted fraction of a NaN for both encodings.
// The 2008 encoding sets the discriminator bit. The legacy encoding
// clears it and, when nothing else is left set, sets the next lower bit
// so the result still reads as a NaN. Assumes FRAC_W >= 2.
module snq_quiet
    import snq_pkg::*;
(
    input  logic [FRAC_W-1:0] frac,
    input  logic              enc2008,
    output logic [FRAC_W-1:0] frac_q
);
    localparam int QPOS = FRAC_W - 1;
    localparam int FPOS = FRAC_W - 2;
    localparam logic [FRAC_W-1:0] QMASK = FRAC_W'(1) << QPOS;
    localparam logic [FRAC_W-1:0] FMASK = FRAC_W'(1) << FPOS;

    logic [FRAC_W-1:0] frac_set;
    logic [FRAC_W-1:0] frac_clr;
    logic [FRAC_W-1:0] frac_leg;

    // Candidate fraction for the 2008 encoding.
    always_comb frac_set = frac | QMASK;

    // Candidate fraction for the legacy encoding, with infinity avoided.
    always_comb begin
        frac_clr = frac & ~QMASK;
        frac_leg = (frac_clr == '0) ? FMASK : frac_clr;
    end

    // Pick the candidate that matches the active encoding.
    always_comb frac_q = enc2008 ? frac_set : frac_leg;
endmodule

// File: rtl/snq_unit.sv
// Module: top of the signaling NaN quieting unit. It splits the operand
// into fields, classifies it, quiets it when it signals, and raises the
// invalid flag at the same time. Combinational: it has no clock and no
// reset.
// Assumes: the encoding bit is stable while op_in is evaluated.
module snq_unit
    import snq_pkg::*;
(
    input  logic [DATA_W-1:0] op_in,
    input  logic              nan2008_mode,
    output logic [DATA_W-1:0] op_out,
    output logic              is_snan,
    output logic              invalid
);
    fp_word_t          word_in;
    fp_word_t          word_out;
    logic              sig_nan;
    logic [FRAC_W-1:0] frac_q;

    // View the incoming bits as sign, exponent and fraction.
    always_comb word_in = fp_word_t'(op_in);

    snq_classify u_classify (
        .expo    (word_in.expo),
        .frac    (word_in.frac),
        .enc2008 (nan2008_mode),
        .sig_nan (sig_nan)
    );

    snq_quiet u_quiet (
        .frac    (word_in.frac),
        .enc2008 (nan2008_mode),
        .frac_q  (frac_q)
    );

    // Substitute the quieted fraction only for a signaling NaN.
    always_comb begin
        word_out      = word_in;
        if (sig_nan) begin
            word_out.frac = frac_q;
        end
    end

    // Drive the result and the two indications.
    always_comb begin
        op_out  = DATA_W'(word_out);
        is_snan = sig_nan;
        invalid = sig_nan;
    end
endmodule

// Checker: relates the unit's ports on every evaluation.
module snq_unit_checks
    import snq_pkg::*;
(
    input logic [DATA_W-1:0] op_in,
    input logic              nan2008_mode,
    input logic [DATA_W-1:0] op_out,
    input logic              is_snan,
    input logic              invalid
);
    localparam int QPOS = FRAC_W - 1;

    fp_word_t a;
    fp_word_t y;
    always_comb a = fp_word_t'(op_in);
    always_comb y = fp_word_t'(op_out);

    always_comb begin
        assert_flag_tracks_R3: assert (invalid == is_snan);
        assert_only_nans_R1: assert (!is_snan || ((&a.expo) && (|a.frac)));
        assert_keep_sign_exp_R7: assert (!is_snan || (y.sign == a.sign && y.expo == a.expo));
        assert_result_quiet_R2: assert (!is_snan ||
            ((&y.expo) && (|y.frac) && (y.frac[QPOS] == nan2008_mode)));
        assert_passthrough_R8: assert (is_snan || op_out == op_in);
    end
endmodule

bind snq_unit snq_unit_checks u_checks (
    .op_in        (op_in),
    .nan2008_mode (nan2008_mode),
    .op_out       (op_out),
    .is_snan      (is_snan),
    .invalid      (invalid)
);

// File: tb/snq_unit_test.sv
module snq_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_in = 32'h0;
    logic        nan2008_mode = 1'b0;
    logic [31:0] op_out;
    logic        is_snan;
    logic        invalid;
    int          total = 0;
    int          bad = 0;
    bit          finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    snq_unit uut (
        .op_in        (op_in),
        .nan2008_mode (nan2008_mode),
        .op_out       (op_out),
        .is_snan      (is_snan),
        .invalid      (invalid)
    );

    // Expected-value model written from the requirements.
    function automatic logic [33:0] model(input logic [31:0] x, input logic m);
        logic [22:0] f;
        logic        nan;
        logic        sg;
        f   = x[22:0];
        nan = (x[30:23] == 8'hFF) && (f != 0);           // R1
        sg  = nan && (m ^ f[22]);                        // R2
        if (sg) begin
            if (m) f[22] = 1'b1;                         // R4
            else begin
                f[22] = 1'b0;                            // R5
                if (f == 0) f = 23'h200000;              // R6
            end
        end
        return {sg, sg, x[31:23], f};                    // R3, R7, R8
    endfunction

    task automatic apply_check(input logic [31:0] x, input logic m, input string req);
        logic [33:0] e;
        @(negedge clk);
        op_in = x;
        nan2008_mode = m;
        #2;
        e = model(x, m);
        total++;
        if ({is_snan, invalid, op_out} !== e) begin
            bad++;
            $display("FAIL %s: in=%h mode=%0d actual snan=%0d inv=%0d out=%h expected snan=%0d inv=%0d out=%h",
                     req, x, m, is_snan, invalid, op_out, e[33], e[32], e[31:0]);
        end
    endtask

    task automatic t_reset_state;
        apply_check(32'h0000_0000, 1'b0, "R8 reset zero");
        apply_check(32'h0000_0000, 1'b1, "R8 reset zero");
    endtask

    task automatic t_literal_cases;
        apply_check(32'h7FC0_0000, 1'b0, "R6 legacy bit22-only");
        if (op_out !== 32'h7FA0_0000) begin bad++; $display("FAIL R6: actual %h expected 7fa00000", op_out); end
        total++;
        apply_check(32'h7F80_0001, 1'b1, "R4 2008 quiet sets bit22");
        if (op_out !== 32'h7FC0_0001) begin bad++; $display("FAIL R4: actual %h expected 7fc00001", op_out); end
        total++;
        apply_check(32'hFFC0_0005, 1'b0, "R5 legacy keep low bits");
        if (op_out !== 32'hFF80_0005) begin bad++; $display("FAIL R5: actual %h expected ff800005", op_out); end
        total++;
    endtask

    task automatic t_payload_corners;
        logic [22:0] pay [8] = '{23'h400000, 23'h000001, 23'h3FFFFF, 23'h7FFFFF,
                                 23'h200000, 23'h400001, 23'h600000, 23'h155555};
        for (int s = 0; s < 2; s++)
            for (int m = 0; m < 2; m++)
                for (int i = 0; i < 8; i++)
                    apply_check({s[0], 8'hFF, pay[i]}, m[0], "R2 R4 R5 R6 R7 payload corner");
    endtask

    task automatic t_non_nan;
        for (int m = 0; m < 2; m++) begin
            apply_check(32'h7F80_0000, m[0], "R1 +infinity");
            apply_check(32'hFF80_0000, m[0], "R1 -infinity");
            apply_check(32'h3F80_0000, m[0], "R1 normal");
            apply_check(32'h8040_0000, m[0], "R1 subnormal bit22");
            apply_check(32'h7F7F_FFFF, m[0], "R1 max normal");
        end
    endtask

    task automatic t_quiet_nan_pass;
        apply_check(32'h7FC0_0000, 1'b1, "R8 2008 quiet NaN");
        apply_check(32'h7F80_1234, 1'b0, "R8 legacy quiet NaN");
        apply_check(32'hFFFF_FFFF, 1'b1, "R8 2008 all ones");
        apply_check(32'hFFBF_FFFF, 1'b0, "R8 legacy quiet");
        apply_check(32'hFFFF_FFFF, 1'b0, "R3 legacy all ones signals");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_literal_cases();
        t_payload_corners();
        t_non_nan();
        t_quiet_nan_pass();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule